// File: doc/BRIEF.md
# Byte-wide frame receive sequencer

This block sits on the host side of an 8-bit bus that reaches an external network controller. Another agent polls the controller and detects that a frame has arrived, because the controller raises no interrupt in this mode. It then pulses `start`. The sequencer first fetches the receive status word and then the frame length word. Each word is read one byte at a time, most significant byte first, so the first read of each word goes to the highest address of the data port. The sequencer then pulls the payload from the data port. Payload reads start at the even address and alternate upward through the port's byte addresses until the whole length has been moved.

Each payload byte leaves on a byte stream with valid, last and ready signals. The status word and the length are presented as outputs. A one-cycle `done` pulse closes each transfer. A bus read is a simple hold-until-acknowledge handshake: `rd_req` and `rd_addr` stay steady until `rd_ack`, and `rd_data` is taken in that cycle.

Top module: `byte_rx_fetch`

## Requirements
- R1: After `start` in idle, the first two bus reads are at DATA_PORT+1 and then DATA_PORT+0, giving the status high byte and then the low byte. `status_word` then holds {high, low}.
- R2: The next two reads fetch the length word in the same high-then-low address order, and `frame_len` then holds {high, low}.
- R3: Payload reads go to DATA_PORT+0, DATA_PORT+1, DATA_PORT+0 and so on. A frame of length N takes exactly 4+N reads. An odd-length frame ends on a DATA_PORT+0 read, with no extra read at DATA_PORT+1.
- R4: Payload bytes appear on `out_data` in read order. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.
- R5: `out_last` is high on the final payload byte and low on every other byte.
- R6: No bus read is requested while an output byte waits in the output register.
- R7: A length of zero makes no payload read and never raises `out_valid`. `done` pulses in the cycle after the acknowledge of the length low byte.
- R8: `done` is high for exactly one cycle, in the cycle after the final byte is accepted. `busy` is high from the cycle after `start` through the `done` cycle and low after it. While `busy` is low, no read is requested and no byte is offered.
- R9: `start` has no effect while `busy` is high, so the read sequence in progress continues unchanged.
- R10: While reset is active, `busy`, `done`, `rd_req` and `out_valid` are low, and `status_word` and `frame_len` are zero.
- R11: Once `rd_req` is raised without `rd_ack`, it stays high in the next cycle with the same `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame arrival detected; begin a transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_req | output | 1 | Bus read request |
| rd_addr | output | ADDR_W | Bus byte address of the read |
| rd_ack | input | 1 | Read completed; `rd_data` valid |
| rd_data | input | 8 | Read data byte |
| status_word | output | WORD_W | Received status word |
| frame_len | output | WORD_W | Received frame length in bytes |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte valid |
| out_last | output | 1 | Final payload byte |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
On every cycle the assertions check the bus-hold rule, the rule that no read is made while a byte waits, the stability of a stalled output byte, the single-cycle `done`, and quiet outputs when idle. Only the bench's frames can show the address order of the status and length bytes, the even/odd payload alternation with its odd-length ending, and the data and last-flag values. The same holds for zero-length handling and for `start` being ignored mid-transfer. These need a device model that knows the expected read sequence.

// File: rtl/frx_pkg.sv
`timescale 1ns/1ps
package frx_pkg;
   typedef enum logic [2:0] {
      FX_IDLE  = 3'd0,
      FX_STAT  = 3'd1,
      FX_LEN   = 3'd2,
      FX_PAY   = 3'd3,
      FX_DRAIN = 3'd4,
      FX_FIN   = 3'd5
   } frx_state_e;
endpackage

// File: rtl/frx_lane_ctr.sv
`timescale 1ns/1ps
// Byte-lane index within one data-port word: loads the top lane for
// high-first word reads, counts down for them and counts up (wrapping)
// for payload reads.
module frx_lane_ctr #(
   parameter int LANES  = 2,
   parameter int LANE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_top,
   input  logic              clr,
   input  logic              dn,
   input  logic              up,
   output logic [LANE_W-1:0] lane,
   output logic              lane_zero
);
   localparam logic [LANE_W-1:0] TOP = LANE_W'(LANES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)       lane <= '0;
      else if (set_top) lane <= TOP;
      else if (clr)     lane <= '0;
      else if (dn)      lane <= lane - 1'b1;
      else if (up)      lane <= (lane == TOP) ? '0 : lane + 1'b1;
   end

   assign lane_zero = (lane == '0);
endmodule

// File: rtl/frx_word_asm.sv
`timescale 1ns/1ps
// Collects bytes into a word, one register per lane.
module frx_word_asm #(
   parameter int LANES  = 2,
   parameter int LANE_W = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [LANE_W-1:0]   lane,
   input  logic [7:0]          byte_in,
   output logic [LANES*8-1:0]  word_q
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            b_q <= '0;
         else if (wr_en && (lane == LANE_W'(g)))
            b_q <= byte_in;
      end
      assign word_q[g*8 +: 8] = b_q;
   end
endmodule

// File: rtl/frx_remain_ctr.sv
`timescale 1ns/1ps
// Payload bytes still to be read.
module frx_remain_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             is_one
);
   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    rem_q <= '0;
      else if (load) rem_q <= load_val;
      else if (dec)  rem_q <= rem_q - 1'b1;
   end

   assign is_one = (rem_q == CNT_W'(1));
endmodule

// File: rtl/frx_out_stage.sv
`timescale 1ns/1ps
// Single output register for the payload stream.
module frx_out_stage (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic [7:0] push_data,
   input  logic       push_last,
   input  logic       out_ready,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_last
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (push) begin
         out_valid <= 1'b1;
         out_data  <= push_data;
         out_last  <= push_last;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/frx_ctrl.sv
`timescale 1ns/1ps
// Transfer sequencer: status word, length word, payload, drain, finish.
module frx_ctrl
   import frx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rd_ack,
   input  logic lane_zero,
   input  logic len_zero,
   input  logic rem_is_one,
   input  logic out_valid,
   input  logic out_fire,
   output logic rd_req,
   output logic lane_set_top,
   output logic lane_clr,
   output logic lane_dn,
   output logic lane_up,
   output logic wr_stat,
   output logic wr_len,
   output logic rem_load,
   output logic rem_dec,
   output logic push,
   output logic push_last,
   output logic busy,
   output logic done
);
   frx_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= FX_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d      = state_q;
      rd_req       = 1'b0;
      lane_set_top = 1'b0;
      lane_clr     = 1'b0;
      lane_dn      = 1'b0;
      lane_up      = 1'b0;
      wr_stat      = 1'b0;
      wr_len       = 1'b0;
      rem_load     = 1'b0;
      rem_dec      = 1'b0;
      push         = 1'b0;
      push_last    = 1'b0;
      done         = 1'b0;
      unique case (state_q)
         FX_IDLE: begin
            if (start) begin
               lane_set_top = 1'b1;
               state_d      = FX_STAT;
            end
         end
         FX_STAT: begin
            rd_req = 1'b1;
            if (rd_ack) begin
               wr_stat = 1'b1;
               if (lane_zero) begin
                  lane_set_top = 1'b1;
                  state_d      = FX_LEN;
               end else begin
                  lane_dn = 1'b1;
               end
            end
         end
         FX_LEN: begin
            rd_req = 1'b1;
            if (rd_ack) begin
               wr_len = 1'b1;
               if (lane_zero) begin
                  lane_clr = 1'b1;
                  if (len_zero) begin
                     state_d = FX_FIN;
                  end else begin
                     rem_load = 1'b1;
                     state_d  = FX_PAY;
                  end
               end else begin
                  lane_dn = 1'b1;
               end
            end
         end
         FX_PAY: begin
            rd_req = !out_valid;
            if (!out_valid && rd_ack) begin
               push      = 1'b1;
               push_last = rem_is_one;
               rem_dec   = 1'b1;
               lane_up   = 1'b1;
               if (rem_is_one) state_d = FX_DRAIN;
            end
         end
         FX_DRAIN: begin
            if (out_fire) state_d = FX_FIN;
         end
         FX_FIN: begin
            done    = 1'b1;
            state_d = FX_IDLE;
         end
         default: state_d = FX_IDLE;
      endcase
   end

   assign busy = (state_q != FX_IDLE);
endmodule

// File: rtl/byte_rx_fetch.sv
`timescale 1ns/1ps
module byte_rx_fetch #(
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int DATA_PORT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [7:0]        rd_data,
   output logic [WORD_W-1:0] status_word,
   output logic [WORD_W-1:0] frame_len,
   output logic [7:0]        out_data,
   output logic              out_valid,
   output logic              out_last,
   input  logic              out_ready
);
   localparam int LANES  = WORD_W / 8;
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

   if ((WORD_W % 8) != 0 || WORD_W < 16) begin : g_bad_word
      $error("WORD_W must be a multiple of 8 and at least 16");
   end
   if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("WORD_W/8 must be a power of two");
   end
   if ((DATA_PORT % LANES) != 0) begin : g_bad_align
      $error("DATA_PORT must be aligned to the word size");
   end
   if ((DATA_PORT + LANES) > (1 << ADDR_W) || ADDR_W <= LANE_W) begin : g_bad_addr
      $error("data port does not fit in ADDR_W");
   end

   logic              lane_set_top, lane_clr, lane_dn, lane_up, lane_zero;
   logic [LANE_W-1:0] lane;
   logic              wr_stat, wr_len, rem_load, rem_dec, rem_is_one;
   logic              push, push_last, out_fire, len_zero;
   logic [WORD_W-1:0] len_full;

   assign out_fire = out_valid && out_ready;
   // lane 0 is the last length byte read, so the full word is known then
   assign len_full = {frame_len[WORD_W-1:8], rd_data};
   assign len_zero = (len_full == '0);
   assign rd_addr  = ADDR_W'(DATA_PORT) + {{(ADDR_W-LANE_W){1'b0}}, lane};

   frx_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_ack(rd_ack),
      .lane_zero(lane_zero), .len_zero(len_zero), .rem_is_one(rem_is_one),
      .out_valid(out_valid), .out_fire(out_fire), .rd_req(rd_req),
      .lane_set_top(lane_set_top), .lane_clr(lane_clr), .lane_dn(lane_dn),
      .lane_up(lane_up), .wr_stat(wr_stat), .wr_len(wr_len),
      .rem_load(rem_load), .rem_dec(rem_dec), .push(push),
      .push_last(push_last), .busy(busy), .done(done)
   );

   frx_lane_ctr #(.LANES(LANES), .LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .set_top(lane_set_top), .clr(lane_clr),
      .dn(lane_dn), .up(lane_up), .lane(lane), .lane_zero(lane_zero)
   );

   frx_word_asm #(.LANES(LANES), .LANE_W(LANE_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_stat), .lane(lane),
      .byte_in(rd_data), .word_q(status_word)
   );

   frx_word_asm #(.LANES(LANES), .LANE_W(LANE_W)) u_len (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_len), .lane(lane),
      .byte_in(rd_data), .word_q(frame_len)
   );

   frx_remain_ctr #(.CNT_W(WORD_W)) u_rem (
      .clk(clk), .rst_n(rst_n), .load(rem_load), .load_val(len_full),
      .dec(rem_dec), .is_one(rem_is_one)
   );

   frx_out_stage u_out (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(rd_data),
      .push_last(push_last), .out_ready(out_ready), .out_data(out_data),
      .out_valid(out_valid), .out_last(out_last)
   );
endmodule

// File: rtl/frx_checker.sv
`timescale 1ns/1ps
module frx_checker #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_data,
   input logic              out_last
);
   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

   // R6
   no_read_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !rd_req);

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req && !out_valid);
endmodule

bind byte_rx_fetch frx_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_req(rd_req),
   .rd_addr(rd_addr), .rd_ack(rd_ack), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/byte_rx_fetch_test.sv
`timescale 1ns/1ps
module byte_rx_fetch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done, rd_req, out_valid, out_last;
   logic [3:0]  rd_addr;
   logic        rd_ack = 1'b0;
   logic [7:0]  rd_data = 8'h00;
   logic [15:0] status_word, frame_len;
   logic [7:0]  out_data;
   logic        out_ready = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   byte_rx_fetch uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .status_word(status_word), .frame_len(frame_len), .out_data(out_data),
      .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
   );

   // {status, length, wait states, ready mode}
   localparam logic [35:0] VECS [6] = '{
      {16'hA5C3, 16'd1,  2'd0, 2'd0},
      {16'h1234, 16'd2,  2'd1, 2'd1},
      {16'h0F0E, 16'd5,  2'd0, 2'd2},
      {16'hBEEF, 16'd8,  2'd2, 2'd0},
      {16'h7001, 16'd3,  2'd1, 2'd2},
      {16'h55AA, 16'd16, 2'd0, 2'd1}
   };

   logic [3:0] exp_addr [64];
   logic [7:0] exp_data [64];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_frame(input logic [15:0] st, input logic [15:0] ln,
                            input int wt, input int rm, input bit mid_start);
      int n, cyc, rd_idx, rx_cnt, done_cnt, wcnt, done_cyc, last_hs, last_ack, ov_seen;
      n = 4 + int'(ln);
      exp_addr[0] = 4'd1; exp_data[0] = st[15:8];
      exp_addr[1] = 4'd0; exp_data[1] = st[7:0];
      exp_addr[2] = 4'd1; exp_data[2] = ln[15:8];
      exp_addr[3] = 4'd0; exp_data[3] = ln[7:0];
      for (int i = 0; i < int'(ln); i++) begin
         exp_addr[4+i] = 4'(i % 2);
         exp_data[4+i] = st[7:0] ^ 8'(i * 13);
      end
      cyc = 0; rd_idx = 0; rx_cnt = 0; done_cnt = 0; wcnt = 0;
      done_cyc = -1; last_hs = -1; last_ack = -1; ov_seen = 0;
      @(negedge clk);
      start = 1'b1;
      while (cyc < 3000) begin
         @(negedge clk);
         cyc++;
         start = (mid_start && cyc == 6);
         case (rm)
            0: out_ready = 1'b1;
            1: out_ready = cyc[0];
            2: out_ready = (cyc % 4 == 3);
            default: out_ready = (cyc >= 30);
         endcase
         if (out_valid) ov_seen++;
         if (out_valid && out_ready) begin
            chk(out_data == exp_data[4+rx_cnt], "R4 payload byte", out_data, exp_data[4+rx_cnt]);
            chk(out_last == (rx_cnt == int'(ln) - 1), "R5 last flag", out_last, rx_cnt == int'(ln) - 1);
            if (out_last) last_hs = cyc;
            rx_cnt++;
         end
         if (rd_req) begin
            if (wcnt == wt) begin
               rd_ack = 1'b1;
               if (rd_idx < n) begin
                  if (rd_idx < 2)
                     chk(rd_addr == exp_addr[rd_idx], "R1 status address", rd_addr, exp_addr[rd_idx]);
                  else if (rd_idx < 4)
                     chk(rd_addr == exp_addr[rd_idx], "R2 length address", rd_addr, exp_addr[rd_idx]);
                  else
                     chk(rd_addr == exp_addr[rd_idx], "R3 payload address", rd_addr, exp_addr[rd_idx]);
                  rd_data = exp_data[rd_idx];
               end else begin
                  chk(1'b0, "R3 extra read", rd_idx, n);
               end
               rd_idx++;
               wcnt = 0;
               last_ack = cyc;
            end else begin
               rd_ack = 1'b0;
               wcnt++;
            end
         end else begin
            rd_ack = 1'b0;
            wcnt = 0;
         end
         if (rm == 3 && cyc == 29)
            chk(rd_idx == 5, "R6 reads held while byte waits", rd_idx, 5);
         if (done) begin
            done_cnt++;
            if (done_cyc < 0) done_cyc = cyc;
         end
         if (done_cyc >= 0 && cyc == done_cyc + 1) begin
            chk(!busy, "R8 busy low after done", busy, 0);
            break;
         end
      end
      rd_ack = 1'b0;
      start = 1'b0;
      if (cyc >= 3000) chk(1'b0, "watchdog frame timeout", cyc, 0);
      chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      chk(status_word == st, "R1 status word", status_word, st);
      chk(frame_len == ln, "R2 frame length", frame_len, ln);
      chk(rd_idx == n, "R3 read count", rd_idx, n);
      chk(rx_cnt == int'(ln), "R4 byte count", rx_cnt, ln);
      if (ln == 0) begin
         chk(done_cyc == last_ack + 1, "R7 done timing", done_cyc, last_ack + 1);
         chk(ov_seen == 0, "R7 no output byte", ov_seen, 0);
      end else begin
         chk(done_cyc == last_hs + 1, "R8 done timing", done_cyc, last_hs + 1);
      end
      if (mid_start)
         chk(rd_idx == n && done_cnt == 1, "R9 start ignored while busy", rd_idx, n);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!busy && !done, "R10 reset busy/done", {busy, done}, 0);
      chk(!rd_req && !out_valid, "R10 reset rd_req/out_valid", {rd_req, out_valid}, 0);
      chk(status_word == 0 && frame_len == 0, "R10 reset words", status_word, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 6; v++) begin
         run_frame(VECS[v][35:20], VECS[v][19:4], int'(VECS[v][3:2]), int'(VECS[v][1:0]), 1'b0);
         repeat (2) @(negedge clk);
      end

      // R7 zero-length frame
      run_frame(16'hC0DE, 16'd0, 0, 0, 1'b0);
      repeat (2) @(negedge clk);
      // R6 sink stalled for a long stretch
      run_frame(16'h2468, 16'd4, 0, 3, 1'b0);
      repeat (2) @(negedge clk);
      // R9 start pulsed in the middle of a transfer
      run_frame(16'h9911, 16'd7, 1, 1, 1'b1);
      repeat (2) @(negedge clk);
      // R3 longest odd frame, last byte from the even address
      run_frame(16'h3C3C, 16'd41, 0, 2, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule